// File: doc/BRIEF.md
# Self-Referenced Read Sequencer

This block reads one resistive memory cell by comparing the cell with itself instead of with a separate reference cell. It first senses the cell and keeps that code. It then writes the cell to a known state and senses it again. It judges the first code against a reference derived from that second code. The read destroys the stored value, so the sequencer writes the recovered bit back before it reports completion.

A mode input picks one of two references, and it is sampled when a read is accepted. In single-reference mode the one known-state code is scaled by a shift-and-add factor so that it sits midway between the two levels. In dual-reference mode the cell is also written to the opposite known state and sensed a third time, and the reference is the mean of the two known-state codes. Analog sensing, current scaling and the write pulses themselves sit outside the block, behind a simple strobe-and-code interface. Sense and write durations are fixed cycle counts set by parameters.

Top module: `srr_read_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, sense enable, capture, write enable, compare strobe and the data output are all 0.
- R2: A read starts with a sense phase of SENSE_CYC cycles, and the capture strobe is high only in its last cycle. The first write that follows carries the known value FIRST_KNOWN (default 0). Single mode captures 2 codes per read and dual mode captures 3.
- R3: In single mode (mode input 0), with c the code sensed after the known write, the bit is 1 only when the first code is strictly greater than c + (c >> shift) (for FIRST_KNOWN = 1: c - (c >> shift)). The reference is formed at CODE_W+1 bits, so it never wraps.
- R4: In dual mode (mode input 1), the second write carries the opposite of FIRST_KNOWN. The bit is 1 only when the first code is strictly greater than the sum of the two known-state codes shifted right by one, with the sum formed without wrap.
- R5: When the recovered bit differs from the last known state written, a restore write of SENSE-independent length WRITE_CYC carries the recovered bit. At done the cell therefore holds the recovered bit.
- R6: When the recovered bit equals the last known state written, no restore write occurs. A read then has 1 write (single mode) or 2 writes (dual mode). With a restore it has 2 or 3.
- R7: Busy is high for exactly 2*SENSE_CYC + WRITE_CYC + 1 cycles in single mode and 3*SENSE_CYC + 2*WRITE_CYC + 1 cycles in dual mode, plus WRITE_CYC when a restore occurs. It falls only in the cycle where done is high.
- R8: Done is high for exactly one cycle, with busy low in that cycle. The data output takes its new value at the edge that ends the compare cycle and holds it until the next compare.
- R9: A start request that arrives while busy is high has no effect: it starts no extra read, adds no done pulse and does not change the current read's length.
- R10: Mode and shift are sampled only when a start is accepted. A change to them during a read does not change that read's write count, length or result.
- R11: Sense enable and write enable are never high together, write enable is high only while busy, and the compare strobe is high for exactly one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, accepted when busy is low |
| mode_i | input | 1 | 0 = single reference, 1 = dual reference |
| shift_i | input | SHIFT_W | Shift amount for the single-mode scale factor |
| sense_en_o | output | 1 | Sense phase active toward the cell |
| hold_o | output | 1 | Capture strobe: the sense code is stored at this edge |
| sense_code_i | input | CODE_W | Digitized sense value from the cell |
| wr_en_o | output | 1 | Write phase active toward the cell |
| wr_bit_o | output | 1 | Value to write during the write phase |
| cmp_o | output | 1 | Compare strobe, one cycle per read |
| data_o | output | 1 | Recovered data bit |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High for the whole read sequence |

## Verification
The bench builds the block with CODE_W = 12, SENSE_CYC = 2, WRITE_CYC = 3 and FIRST_KNOWN = 0. Unequal sense and write lengths make every phase count visible separately in the busy length, and a miscounted phase shows up as a wrong cycle total. With 12-bit codes, a near-full-scale known code pushes the single-mode reference past 4095, and a pair of near-full-scale codes fills the dual-mode sum, so both no-wrap cases can be reached. An exact tie between the first code and the reference exercises the strict comparison.

// File: rtl/srr_pkg.sv
package srr_pkg;

    localparam int SRR_CODE_W = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SNS1,
        ST_WRK1,
        ST_SNS2,
        ST_WRK2,
        ST_SNS3,
        ST_CMP,
        ST_RSTR,
        ST_DONE
    } srr_state_e;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } srr_mode_e;

    typedef struct packed {
        logic       sense_en;
        logic       hold;
        logic [1:0] slot;
        logic       wr_en;
        logic       wr_bit;
        logic       cmp;
        logic       done;
        logic       busy;
    } srr_ctl_t;

    function automatic int srr_cnt_w(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

    function automatic logic srr_is_sense(input srr_state_e s);
        return (s == ST_SNS1) || (s == ST_SNS2) || (s == ST_SNS3);
    endfunction

    function automatic logic srr_is_write(input srr_state_e s);
        return (s == ST_WRK1) || (s == ST_WRK2) || (s == ST_RSTR);
    endfunction

endpackage

// File: rtl/srr_fsm.sv
module srr_fsm
    import srr_pkg::*;
#(
    parameter int SENSE_CYC   = 2,
    parameter int WRITE_CYC   = 3,
    parameter int SHIFT_W     = 4,
    parameter bit FIRST_KNOWN = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               bit_now_i,
    input  logic               rec_bit_i,
    output srr_ctl_t           ctl_o,
    output srr_mode_e          mode_q_o,
    output logic [SHIFT_W-1:0] shift_q_o
);

    localparam int CNT_W = srr_cnt_w(SENSE_CYC, WRITE_CYC);
    localparam logic [CNT_W-1:0] SENSE_LD = CNT_W'(SENSE_CYC - 1);
    localparam logic [CNT_W-1:0] WRITE_LD = CNT_W'(WRITE_CYC - 1);
    localparam logic KNOWN_A = FIRST_KNOWN;
    localparam logic KNOWN_B = ~FIRST_KNOWN;

    srr_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_ld;
    srr_mode_e          mode_q;
    logic [SHIFT_W-1:0] shift_q;
    logic               phase_last;
    logic               idle_like;
    logic               last_known;

    assign phase_last = (cnt_q == '0);
    assign idle_like  = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign last_known = (mode_q == MODE_DUAL) ? KNOWN_B : KNOWN_A;

    // step sequencing
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) state_d = ST_SNS1;
                else         state_d = ST_IDLE;
            end
            ST_SNS1: if (phase_last) state_d = ST_WRK1;
            ST_WRK1: if (phase_last) state_d = ST_SNS2;
            ST_SNS2: if (phase_last) state_d = (mode_q == MODE_DUAL) ? ST_WRK2 : ST_CMP;
            ST_WRK2: if (phase_last) state_d = ST_SNS3;
            ST_SNS3: if (phase_last) state_d = ST_CMP;
            ST_CMP:  state_d = (bit_now_i != last_known) ? ST_RSTR : ST_DONE;
            ST_RSTR: if (phase_last) state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (srr_is_sense(state_d))      cnt_ld = SENSE_LD;
        else if (srr_is_write(state_d)) cnt_ld = WRITE_LD;
        else                            cnt_ld = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= MODE_SINGLE;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= cnt_ld;
            else if (!phase_last)   cnt_q <= cnt_q - 1'b1;
            if (idle_like && start_i) begin
                mode_q  <= srr_mode_e'(mode_i);
                shift_q <= shift_i;
            end
        end
    end

    // strobes toward the cell and the datapath
    always_comb begin
        ctl_o          = '0;
        ctl_o.sense_en = srr_is_sense(state_q);
        ctl_o.hold     = srr_is_sense(state_q) && phase_last;
        ctl_o.wr_en    = srr_is_write(state_q);
        ctl_o.cmp      = (state_q == ST_CMP);
        ctl_o.done     = (state_q == ST_DONE);
        ctl_o.busy     = !idle_like;
        unique case (state_q)
            ST_SNS2: ctl_o.slot = 2'd1;
            ST_SNS3: ctl_o.slot = 2'd2;
            default: ctl_o.slot = 2'd0;
        endcase
        unique case (state_q)
            ST_WRK1: ctl_o.wr_bit = KNOWN_A;
            ST_WRK2: ctl_o.wr_bit = KNOWN_B;
            ST_RSTR: ctl_o.wr_bit = rec_bit_i;
            default: ctl_o.wr_bit = 1'b0;
        endcase
    end

    assign mode_q_o  = mode_q;
    assign shift_q_o = shift_q;

endmodule

// File: rtl/srr_hold.sv
module srr_hold #(
    parameter int CODE_W = 12,
    parameter int NSLOT  = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cap_i,
    input  logic [1:0]                   slot_i,
    input  logic [CODE_W-1:0]            code_i,
    output logic [NSLOT-1:0][CODE_W-1:0] vals_o
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                  vals_o[g] <= '0;
            else if (cap_i && (slot_i == 2'(g)))      vals_o[g] <= code_i;
        end
    end

endmodule

// File: rtl/srr_judge.sv
module srr_judge
    import srr_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SHIFT_W     = 4,
    parameter bit FIRST_KNOWN = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0][CODE_W-1:0]   vals_i,
    input  srr_mode_e                mode_i,
    input  logic [SHIFT_W-1:0]       shift_i,
    input  logic                     cmp_i,
    output logic                     bit_now_o,
    output logic                     data_o
);

    localparam int EXT_W = CODE_W + 1;

    logic [EXT_W-1:0] cell_x, knw1_x, knw2_x;
    logic [EXT_W-1:0] ref_single, ref_dual, ref_sel;
    logic [EXT_W-1:0] dual_sum;

    assign cell_x = {1'b0, vals_i[0]};
    assign knw1_x = {1'b0, vals_i[1]};
    assign knw2_x = {1'b0, vals_i[2]};

    // known level low: raise it toward the midpoint; known level high: lower it
    if (FIRST_KNOWN == 1'b0) begin : g_scale_up
        assign ref_single = knw1_x + (knw1_x >> shift_i);
    end else begin : g_scale_down
        assign ref_single = knw1_x - (knw1_x >> shift_i);
    end

    assign dual_sum = knw1_x + knw2_x;
    assign ref_dual = dual_sum >> 1;
    assign ref_sel  = (mode_i == MODE_DUAL) ? ref_dual : ref_single;

    assign bit_now_o = (cell_x > ref_sel);

    always_ff @(posedge clk) begin
        if (rst)        data_o <= 1'b0;
        else if (cmp_i) data_o <= bit_now_o;
    end

endmodule

// File: rtl/srr_read_seq.sv
module srr_read_seq
    import srr_pkg::*;
#(
    parameter int CODE_W      = SRR_CODE_W,
    parameter int SHIFT_W     = $clog2(CODE_W),
    parameter int SENSE_CYC   = 2,
    parameter int WRITE_CYC   = 3,
    parameter bit FIRST_KNOWN = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               sense_en_o,
    output logic               hold_o,
    input  logic [CODE_W-1:0]  sense_code_i,
    output logic               wr_en_o,
    output logic               wr_bit_o,
    output logic               cmp_o,
    output logic               data_o,
    output logic               done_o,
    output logic               busy_o
);

    localparam int NSLOT = 3;

    srr_ctl_t                     ctl;
    srr_mode_e                    mode_q;
    logic [SHIFT_W-1:0]           shift_q;
    logic [NSLOT-1:0][CODE_W-1:0] vals;
    logic                         bit_now;
    logic                         rec_bit;

    srr_fsm #(
        .SENSE_CYC  (SENSE_CYC),
        .WRITE_CYC  (WRITE_CYC),
        .SHIFT_W    (SHIFT_W),
        .FIRST_KNOWN(FIRST_KNOWN)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .shift_i  (shift_i),
        .bit_now_i(bit_now),
        .rec_bit_i(rec_bit),
        .ctl_o    (ctl),
        .mode_q_o (mode_q),
        .shift_q_o(shift_q)
    );

    srr_hold #(
        .CODE_W(CODE_W),
        .NSLOT (NSLOT)
    ) u_hold (
        .clk   (clk),
        .rst   (rst),
        .cap_i (ctl.hold),
        .slot_i(ctl.slot),
        .code_i(sense_code_i),
        .vals_o(vals)
    );

    srr_judge #(
        .CODE_W     (CODE_W),
        .SHIFT_W    (SHIFT_W),
        .FIRST_KNOWN(FIRST_KNOWN)
    ) u_judge (
        .clk      (clk),
        .rst      (rst),
        .vals_i   (vals),
        .mode_i   (mode_q),
        .shift_i  (shift_q),
        .cmp_i    (ctl.cmp),
        .bit_now_o(bit_now),
        .data_o   (rec_bit)
    );

    assign sense_en_o = ctl.sense_en;
    assign hold_o     = ctl.hold;
    assign wr_en_o    = ctl.wr_en;
    assign wr_bit_o   = ctl.wr_bit;
    assign cmp_o      = ctl.cmp;
    assign done_o     = ctl.done;
    assign busy_o     = ctl.busy;
    assign data_o     = rec_bit;

endmodule

// File: rtl/srr_checks.sv
module srr_checks (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic mode_q,
    input logic sense_en_o,
    input logic hold_o,
    input logic wr_en_o,
    input logic cmp_o,
    input logic data_o,
    input logic done_o,
    input logic busy_o
);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(cmp_o) |-> $stable(data_o));

    assert_busy_ends_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    assert_start_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !cmp_o) |=> busy_o);

    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(mode_q));

    assert_capture_in_sense_R2: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> sense_en_o);

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(sense_en_o && wr_en_o));

    assert_write_busy_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> busy_o);

    assert_cmp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        cmp_o |=> !cmp_o);

endmodule

bind srr_read_seq srr_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .mode_q    (mode_q),
    .sense_en_o(sense_en_o),
    .hold_o    (hold_o),
    .wr_en_o   (wr_en_o),
    .cmp_o     (cmp_o),
    .data_o    (data_o),
    .done_o    (done_o),
    .busy_o    (busy_o)
);

// File: tb/srr_read_seq_test.sv
`timescale 1ns/1ps
module srr_read_seq_test;

    localparam int CODE_W = 12;
    localparam int SHIFT_W = 4;
    localparam int SC = 2;
    localparam int WC = 3;

    typedef struct packed {
        logic       mode;
        logic       bitv;
        logic [7:0] cycles;
        logic [3:0] writes;
        logic [3:0] holds;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic [SHIFT_W-1:0] shift_i = '0;
    logic sense_en_o, hold_o, wr_en_o, wr_bit_o, cmp_o, data_o, done_o, busy_o;
    logic [CODE_W-1:0] sense_code_i;

    // behavioural cell
    logic cell_q = 1'b0;
    logic preset_req = 1'b0;
    logic preset_val = 1'b0;
    int   code_lo = 0;
    int   code_hi = 0;

    int nchk = 0;
    int nerr = 0;
    int nreads = 0;
    int ndone = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    srr_read_seq #(
        .CODE_W(CODE_W), .SHIFT_W(SHIFT_W),
        .SENSE_CYC(SC), .WRITE_CYC(WC), .FIRST_KNOWN(1'b0)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .shift_i(shift_i),
        .sense_en_o(sense_en_o), .hold_o(hold_o), .sense_code_i(sense_code_i),
        .wr_en_o(wr_en_o), .wr_bit_o(wr_bit_o), .cmp_o(cmp_o), .data_o(data_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    assign sense_code_i = cell_q ? CODE_W'(code_hi) : CODE_W'(code_lo);

    always @(posedge clk) begin
        if (wr_en_o)         cell_q <= wr_bit_o;
        else if (preset_req) cell_q <= preset_val;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per done pulse
    int   bcnt = 0, wcnt = 0, hcnt = 0, ccnt = 0;
    logic wr_prev = 1'b0, done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            bcnt = 0; wcnt = 0; hcnt = 0; ccnt = 0;
            wr_prev = 1'b0; done_prev = 1'b0;
        end else begin
            if (busy_o) bcnt++;
            if (hold_o) hcnt++;
            if (cmp_o)  ccnt++;
            if (wr_en_o && !wr_prev) begin
                wcnt++;
                if (wcnt == 1) chk("R2", "first known write value", int'(wr_bit_o), 0);
                if (wcnt == 2 && q.size() != 0 && q[0].mode)
                    chk("R4", "second known write value", int'(wr_bit_o), 1);
            end
            wr_prev = wr_en_o;
            if (done_o) begin
                ndone++;
                chk("R8", "done longer than one cycle", int'(done_prev), 0);
                chk("R8", "busy during done", int'(busy_o), 0);
                if (q.size() == 0) begin
                    chk("R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.mode ? "R4" : "R3", "recovered bit", int'(data_o), int'(e.bitv));
                    chk("R7", "busy cycles", bcnt, int'(e.cycles));
                    chk("R6", "write count", wcnt, int'(e.writes));
                    chk("R5", "cell after read", int'(cell_q), int'(e.bitv));
                    chk("R2", "captures", hcnt, int'(e.holds));
                    chk("R11", "compare strobes", ccnt, 1);
                end
                bcnt = 0; wcnt = 0; hcnt = 0; ccnt = 0;
            end
            done_prev = done_o;
        end
    end

    task automatic do_read(input logic b, input int lo, input int hi,
                           input logic m, input int k, input logic disturb);
        exp_t e;
        int   rf, v0;
        logic bt;
        v0 = b ? hi : lo;
        if (!m) begin
            rf = lo + (lo >> k);
            bt = (v0 > rf);
            e.writes = bt ? 4'd2 : 4'd1;
            e.cycles = 8'(2*SC + WC + 1 + (bt ? WC : 0));
            e.holds  = 4'd2;
        end else begin
            rf = (lo + hi) >> 1;
            bt = (v0 > rf);
            e.writes = bt ? 4'd2 : 4'd3;
            e.cycles = 8'(3*SC + 2*WC + 1 + (bt ? 0 : WC));
            e.holds  = 4'd3;
        end
        e.mode = m;
        e.bitv = bt;
        @(negedge clk);
        code_lo = lo; code_hi = hi;
        preset_val = b; preset_req = 1'b1;
        @(negedge clk);
        preset_req = 1'b0;
        q.push_back(e);
        nreads++;
        start_i = 1'b1; mode_i = m; shift_i = SHIFT_W'(k);
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; mode_i = ~m; shift_i = SHIFT_W'(k + 3);
            @(negedge clk);
            start_i = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R8", "data held after done", int'(data_o), int'(bt));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy_o), 0);
        chk("R1", "done in reset", int'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy_o), 0);
        chk("R1", "sense/write/cmp after reset", int'({sense_en_o, hold_o, wr_en_o, cmp_o}), 0);
        chk("R1", "data after reset", int'(data_o), 0);

        // R3 single mode, both stored values, restore and skip
        do_read(1'b1, 1000, 2200, 1'b0, 1, 1'b0);
        do_read(1'b0, 1000, 2200, 1'b0, 1, 1'b0);
        // R3 strict comparison at an exact tie
        do_read(1'b1, 1000, 1500, 1'b0, 1, 1'b0);
        // R3 other scale factor
        do_read(1'b1, 1000, 1300, 1'b0, 2, 1'b0);
        // R3 reference above full scale does not wrap
        do_read(1'b1, 3000, 4095, 1'b0, 1, 1'b0);
        // R4 dual mode both values
        do_read(1'b1, 800, 1800, 1'b1, 0, 1'b0);
        do_read(1'b0, 800, 1800, 1'b1, 0, 1'b0);
        // R4 full-scale sum without wrap
        do_read(1'b1, 4094, 4095, 1'b1, 0, 1'b0);
        // R4 tie on the mean
        do_read(1'b0, 1001, 1002, 1'b1, 0, 1'b0);
        // R9 and R10: start, mode and shift changed mid-read
        do_read(1'b1, 1000, 2200, 1'b0, 1, 1'b1);
        do_read(1'b0, 800, 1800, 1'b1, 0, 1'b1);

        repeat (20) @(negedge clk);
        chk("R9", "done pulses per accepted read", ndone, nreads);
        chk("R9", "no read started by ignored requests", int'(busy_o), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule